// File: doc/BRIEF.md
# Demodulator Lock Status and Parameter-Change Interrupt

This block gathers the synchronization state of a terrestrial OFDM receive chain. Five lock indications arrive from the chain: frame sync, frequency lock, FFT start timing, sampling-clock lock and transmission-parameter frame validity. The block registers all five as current lock flags. Whenever any of them changes value, it sets a sticky sync-change event.

Once per OFDM frame a strobe presents the decoded transmission-parameter (TPS) word together with a flag that says whether the word passed its BCH check. On each frame whose word passed, the block compares the word against its stored copy. Any difference outside the frame-number field sets a sticky interrupt. The word is then stored, so that the next frame is compared against the newest valid parameters.

A processor reads the block through a registered read port. A read of the status address returns the five flags and both sticky bits, and clears the sticky bits. A second address returns the stored parameter word. The TPS word width and the position and width of the frame-number field are parameters.

Top module: `demod_status_irq`

## Requirements
- R1: Reset clears the five lock flags, both sticky bits, the stored TPS word, `irq_o`, `sync_chg_o` and `rd_data_o`.
- R2: The status word holds, in bits [4:0], the lock inputs registered one cycle earlier. Bit 0 is frame sync, bit 1 frequency lock, bit 2 FFT start, bit 3 sampling clock and bit 4 TPS validity. Bits above 6 read as zero.
- R3: When the lock inputs differ from the held flags at a clock edge, the sync-change bit (status bit 5, also on `sync_chg_o`) becomes 1 at that edge. It stays 1 until it is cleared.
- R4: On a cycle where `frame_stb_i` and `tps_bch_ok_i` are both high, a difference between `tps_word_i` and the stored word outside the frame-number field sets the TPS-change bit at that edge. This bit is status bit 6, and `irq_o` equals it.
- R5: A difference confined to the frame-number field (`FN_W` bits starting at `FN_LSB`) does not set the TPS-change bit.
- R6: A word that failed the BCH check, or any word presented without `frame_stb_i`, neither sets the TPS-change bit nor alters the stored word.
- R7: Every word that passed the BCH check and arrived with the strobe is stored. It can be read at address 1, zero-extended, and it is the reference for the next comparison.
- R8: A read strobe at address 0 clears both sticky bits at that edge. Reads at any other address clear nothing.
- R9: If a set condition and a clearing read fall on the same edge, the sticky bit ends at 1.
- R10: `rd_data_o` loads on the edge where `rd_stb_i` is high, with the values held just before that edge. Addresses 2 and 3 return zero. Without a strobe, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 5 | Lock indications from the receive chain, ordered as in R2 |
| tps_word_i | input | TPS_W | Decoded transmission-parameter word |
| tps_bch_ok_i | input | 1 | The word passed its BCH check |
| frame_stb_i | input | 1 | One-cycle strobe, once per OFDM frame |
| rd_stb_i | input | 1 | Single-cycle read strobe |
| rd_addr_i | input | ADDR_W | Read address: 0 status, 1 stored TPS word |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | TPS-change interrupt, equal to the sticky bit |
| sync_chg_o | output | 1 | Sticky sync-change event |

## Verification
The lock flags are swept through all 32 patterns in counting order. This separates single-bit changes from multi-bit changes and from the no-change step at pattern 0, and each step is read back immediately or after an idle cycle.

The parameter comparison is driven with all 256 values of an 8-bit word, with a frame-number field of 2 bits at bit 2. The BCH flag fails on a fixed pattern, and each value is preceded by a mismatching word presented without the strobe. This tells a real parameter change apart from a failed word, an unstrobed word and a frame-number-only step.

Directed cases cover three things: a read landing on the same edge as a set, reads of the non-clearing addresses, and holding of the read data.

// File: rtl/dsi_pkg.sv
`timescale 1ns/1ps
package dsi_pkg;
    localparam int LOCK_N      = 5;
    localparam int LK_FRAME    = 0;
    localparam int LK_FREQ     = 1;
    localparam int LK_START    = 2;
    localparam int LK_SCLK     = 3;
    localparam int LK_TPS      = 4;
    localparam int ST_SYNC_BIT = 5;
    localparam int ST_TPS_BIT  = 6;
    localparam int RA_STATUS   = 0;
    localparam int RA_TPS      = 1;

    typedef logic [LOCK_N-1:0] lock_vec_t;
endpackage

// File: rtl/dsi_lock_track.sv
`timescale 1ns/1ps
module dsi_lock_track
    import dsi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lock_vec_t lock_i,
    input  logic      clr_i,
    output lock_vec_t lock_o,
    output logic      evt_o
);
    typedef struct packed {
        lock_vec_t lock;
        logic      evt;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lock = lock_i;
        if (clr_i) begin
            st_d.evt = 1'b0;
        end
        // a new value wins over a clearing read in the same cycle
        if (lock_i != st_q.lock) begin
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
    assign evt_o  = st_q.evt;
endmodule

// File: rtl/dsi_tps_watch.sv
`timescale 1ns/1ps
module dsi_tps_watch #(
    parameter int TPS_W  = 16,
    parameter int FN_LSB = 0,
    parameter int FN_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TPS_W-1:0] tps_i,
    input  logic             bch_ok_i,
    input  logic             frame_stb_i,
    input  logic             clr_i,
    output logic [TPS_W-1:0] held_o,
    output logic             chg_o
);
    typedef struct packed {
        logic [TPS_W-1:0] held;
        logic             chg;
    } tw_state_t;

    tw_state_t        st_d, st_q;
    logic [TPS_W-1:0] cmp_mask;
    logic             take;
    logic             differs;

    generate
        if (FN_W > 0) begin : g_fn_mask
            localparam logic [TPS_W-1:0] FN_ONES = {{(TPS_W-FN_W){1'b0}}, {FN_W{1'b1}}};
            assign cmp_mask = ~(FN_ONES << FN_LSB);
        end else begin : g_no_fn
            assign cmp_mask = '1;
        end
    endgenerate

    assign take    = frame_stb_i && bch_ok_i;
    assign differs = |((tps_i ^ st_q.held) & cmp_mask);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.chg = 1'b0;
        end
        if (take) begin
            st_d.held = tps_i;
            if (differs) begin
                st_d.chg = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;
    assign chg_o  = st_q.chg;
endmodule

// File: rtl/dsi_rd_port.sv
`timescale 1ns/1ps
module dsi_rd_port
    import dsi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2,
    parameter int TPS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  lock_vec_t         lock_i,
    input  logic              sync_evt_i,
    input  logic              tps_evt_i,
    input  logic [TPS_W-1:0]  held_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              clr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rp_state_t;

    rp_state_t         st_d, st_q;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] tps_w;

    always_comb begin
        status_w                 = '0;
        status_w[LOCK_N-1:0]     = lock_i;
        status_w[ST_SYNC_BIT]    = sync_evt_i;
        status_w[ST_TPS_BIT]     = tps_evt_i;
        tps_w                    = '0;
        tps_w[TPS_W-1:0]         = held_i;
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb_i) begin
            if (rd_addr_i == ADDR_W'(RA_STATUS)) begin
                st_d.data = status_w;
            end else if (rd_addr_i == ADDR_W'(RA_TPS)) begin
                st_d.data = tps_w;
            end else begin
                st_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;
    assign clr_o     = rd_stb_i && (rd_addr_i == ADDR_W'(RA_STATUS));
endmodule

// File: rtl/demod_status_irq.sv
`timescale 1ns/1ps
module demod_status_irq
    import dsi_pkg::*;
#(
    parameter int TPS_W  = 16,
    parameter int FN_LSB = 0,
    parameter int FN_W   = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        lock_i,
    input  logic [TPS_W-1:0]  tps_word_i,
    input  logic              tps_bch_ok_i,
    input  logic              frame_stb_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              sync_chg_o
);
    lock_vec_t        lock_q;
    logic             sync_evt;
    logic             tps_evt;
    logic [TPS_W-1:0] held;
    logic             rd_clr;

    dsi_lock_track u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (lock_i),
        .clr_i  (rd_clr),
        .lock_o (lock_q),
        .evt_o  (sync_evt)
    );

    dsi_tps_watch #(
        .TPS_W  (TPS_W),
        .FN_LSB (FN_LSB),
        .FN_W   (FN_W)
    ) u_tps (
        .clk         (clk),
        .rst_n       (rst_n),
        .tps_i       (tps_word_i),
        .bch_ok_i    (tps_bch_ok_i),
        .frame_stb_i (frame_stb_i),
        .clr_i       (rd_clr),
        .held_o      (held),
        .chg_o       (tps_evt)
    );

    dsi_rd_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .TPS_W  (TPS_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb_i   (rd_stb_i),
        .rd_addr_i  (rd_addr_i),
        .lock_i     (lock_q),
        .sync_evt_i (sync_evt),
        .tps_evt_i  (tps_evt),
        .held_i     (held),
        .rd_data_o  (rd_data_o),
        .clr_o      (rd_clr)
    );

    assign irq_o      = tps_evt;
    assign sync_chg_o = sync_evt;
endmodule

// File: rtl/dsi_checker.sv
`timescale 1ns/1ps
module dsi_checker #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        lock_i,
    input logic [4:0]        lock_q,
    input logic              frame_stb_i,
    input logic              tps_bch_ok_i,
    input logic              rd_stb_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              irq_o,
    input logic              sync_chg_o
);
    logic status_rd;
    assign status_rd = rd_stb_i && (rd_addr_i == '0);

    AST_LOCK_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i != lock_q) |=> sync_chg_o); // R3
    AST_LOCK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lock_q == $past(lock_i))); // R2
    AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_chg_o && !status_rd) |=> sync_chg_o); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !status_rd) |=> irq_o); // R8
    AST_IRQ_NEEDS_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(frame_stb_i && tps_bch_ok_i)); // R6
    AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !frame_stb_i) |=> !irq_o); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && (lock_i != lock_q)) |=> sync_chg_o); // R9
endmodule

bind demod_status_irq dsi_checker #(.ADDR_W(ADDR_W)) u_dsi_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock_i),
    .lock_q       (lock_q),
    .frame_stb_i  (frame_stb_i),
    .tps_bch_ok_i (tps_bch_ok_i),
    .rd_stb_i     (rd_stb_i),
    .rd_addr_i    (rd_addr_i),
    .irq_o        (irq_o),
    .sync_chg_o   (sync_chg_o)
);

// File: tb/demod_status_irq_test.sv
`timescale 1ns/1ps
module demod_status_irq_test;
    localparam int CLK_P  = 10;
    localparam int TPS_W  = 8;
    localparam int FN_LSB = 2;
    localparam int FN_W   = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam logic [TPS_W-1:0] CMP = ~(TPS_W'((1 << FN_W) - 1) << FN_LSB);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        lock_i = '0;
    logic [TPS_W-1:0]  tps_word_i = '0;
    logic              tps_bch_ok_i = 1'b0;
    logic              frame_stb_i = 1'b0;
    logic              rd_stb_i = 1'b0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              irq_o;
    logic              sync_chg_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_P/2) clk = ~clk;

    demod_status_irq #(
        .TPS_W(TPS_W), .FN_LSB(FN_LSB), .FN_W(FN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .tps_word_i(tps_word_i),
        .tps_bch_ok_i(tps_bch_ok_i), .frame_stb_i(frame_stb_i), .rd_stb_i(rd_stb_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .sync_chg_o(sync_chg_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        rd_stb_i  = 1'b1;
        rd_addr_i = a;
        tick();
        rd_stb_i  = 1'b0;
        d = rd_data_o;
    endtask

    task automatic frame(input logic [TPS_W-1:0] w, input logic ok);
        tps_word_i   = w;
        tps_bch_ok_i = ok;
        frame_stb_i  = 1'b1;
        tick();
        frame_stb_i  = 1'b0;
        tps_bch_ok_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [4:0]        prev;
        logic [TPS_W-1:0]  store;
        logic              irqm;
        logic              setc;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "irq", irq_o, 0);
        chk("R1", "sync", sync_chg_o, 0);
        chk("R1", "rd_data", rd_data_o, 0);
        rst_n = 1'b1;
        rd(0, d); chk("R1", "status", d, 0);
        rd(1, d); chk("R1", "tps store", d, 0);

        // R2 R3 sweep of lock patterns
        prev = '0;
        for (int p = 0; p < 32; p++) begin
            lock_i = 5'(p);
            tick();
            chk("R3", "sync event", sync_chg_o, (5'(p) != prev));
            if (p % 2 == 1) begin
                tick();
                chk("R3", "sync sticky", sync_chg_o, (5'(p) != prev));
            end
            rd(0, d);
            chk("R2", "lock flags", d[4:0], p);
            chk("R2", "upper bits", d[DATA_W-1:7], 0);
            chk("R3", "status sync bit", d[5], (5'(p) != prev));
            chk("R8", "sync cleared", sync_chg_o, 0);
            prev = 5'(p);
        end

        // R4 R6 R7 sweep over TPS words
        store = '0;
        irqm  = 1'b0;
        for (int w = 0; w < 256; w++) begin
            tps_word_i   = ~store;
            tps_bch_ok_i = 1'b1;
            tick();
            chk("R6", "no strobe no irq", irq_o, irqm);
            frame(8'(w), (w % 5) != 2);
            setc = ((w % 5) != 2) && (((8'(w) ^ store) & CMP) != 0);
            if ((w % 5) != 2) store = 8'(w);
            irqm = irqm | setc;
            chk((w % 5) != 2 ? "R4" : "R6", "irq after frame", irq_o, irqm);
            if (w % 3 == 0) begin
                rd(1, d);
                chk("R7", "stored word", d, store);
                rd(0, d);
                chk("R8", "status tps bit", d[6], irqm);
                irqm = 1'b0;
                chk("R8", "irq cleared", irq_o, 0);
            end
        end
        rd(0, d);

        // R5 frame-number-only differences
        frame(8'hA1, 1'b1);
        rd(0, d);
        chk("R8", "irq cleared", irq_o, 0);
        for (int k = 1; k < 4; k++) begin
            frame(8'hA1 ^ 8'(k << FN_LSB), 1'b1);
            chk("R5", "fn only no irq", irq_o, 0);
            rd(1, d);
            chk("R7", "fn word stored", d, 8'hA1 ^ 8'(k << FN_LSB));
        end
        store = 8'hA1 ^ 8'(3 << FN_LSB);
        frame(store ^ 8'h80, 1'b1);
        chk("R4", "upper bit irq", irq_o, 1);
        store = store ^ 8'h80;
        rd(0, d);

        // R9 set and clear on the same edge
        tps_word_i   = store ^ 8'h01;
        tps_bch_ok_i = 1'b1;
        frame_stb_i  = 1'b1;
        lock_i       = lock_i ^ 5'h01;
        rd_stb_i     = 1'b1;
        rd_addr_i    = 0;
        tick();
        rd_stb_i = 1'b0; frame_stb_i = 1'b0; tps_bch_ok_i = 1'b0;
        chk("R9", "irq set wins", irq_o, 1);
        chk("R9", "sync set wins", sync_chg_o, 1);
        chk("R9", "read saw old tps bit", rd_data_o[6], 0);
        chk("R9", "read saw old sync bit", rd_data_o[5], 0);

        // R8 R10 other addresses
        rd(2, d);
        chk("R10", "addr2 zero", d, 0);
        chk("R8", "addr2 keeps irq", irq_o, 1);
        chk("R8", "addr2 keeps sync", sync_chg_o, 1);
        rd(3, d);
        chk("R10", "addr3 zero", d, 0);
        rd(1, d);
        chk("R10", "addr1 tps", d, store ^ 8'h01);
        tick();
        chk("R10", "data holds", rd_data_o, store ^ 8'h01);
        rd(0, d);
        chk("R10", "status snapshot", d, {9'b0, 2'b11, lock_i});
        chk("R8", "both cleared", {irq_o, sync_chg_o}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule